// File: doc/BRIEF.md
# Decade Autoranging Range Controller

This block chooses one of eight decade current ranges for a picoammeter front end. Each new four-digit BCD reading is judged against a fixed window. A reading that is too small moves the range one decade more sensitive. A reading that is too large, or one carrying an overload flag, sends the range back to the least sensitive decade. The walk toward more sensitive ranges then starts again. Ranging only ever moves toward more sensitive ranges, except for the jump back to the top.

The controller evaluates a reading a fixed number of cycles after the rising edge of the new-reading strobe, which gives the BCD lines time to settle. It honours a front-panel HOLD/AUTO selector, a momentary DOWN button that wraps around, and a reset-to-least-sensitive control with a remote twin. Remote zero-check and remote range-hold lines block automatic steps.

The outputs are the 3-bit range code, a one-hot relay select, a BCD exponent digit and a ranging flag that marks readings as invalid. A display-blank flag reports an over-range reading taken while in HOLD.

Top module: `decade_range_ctrl`

## Requirements
- R1: After reset the range code is 000 (least sensitive, 1e-2 A), and both the ranging flag and the blank flag are low. Code 111 is the most sensitive range (1e-9 A).
- R2: `relay_sel` has exactly one bit high, and that bit is the one indexed by the range code. `range_exp` is the code plus 2, so it runs from 2 to 9.
- R3: Under-range: when the thousands digit `rd_bcd[15:12]` and the hundreds digit `rd_bcd[11:8]` are both zero (value below 0100), an evaluation moves the code up by one. At code 111 the code stays where it is.
- R4: Over-range: when `rd_ovl` is high or the thousands digit is above 1 (value above 1999), an evaluation sets the code to 000. Readings from 0100 to 1999 leave the code unchanged.
- R5: An evaluation takes place exactly SETTLE_CYC cycles after the clock edge that sees `rd_strobe` rise. It happens only once per rising edge, however long the strobe stays high.
- R6: Each rising edge of `down_btn` moves the code up by one, and a press at 111 wraps to 000. A held button steps only once.
- R7: While `rst_rng_btn` or `rst_rng_remote` is high outside HOLD, the code is forced to 000 and evaluations are ignored. Normal ranging resumes after release.
- R8: While `zero_chk_remote` or `rng_hold_remote` is high, evaluations change neither the code nor the ranging flag. DOWN presses still act.
- R9: In HOLD (`hold_mode`=1) the code is frozen, and DOWN and the reset controls are ignored. An over-range evaluation raises `ovl_blank`, and an in-range evaluation clears it.
- R10: When `hold_mode` falls, the code goes to 000, the ranging flag rises and `ovl_blank` clears, all at the next edge.
- R11: `ranging` goes high on every automatic step. It goes low on an evaluation that needs no step, and it stays low while HOLD, zero-check or range-hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_bcd | input | 16 | Reading, four BCD digits, thousands digit in [15:12] |
| rd_ovl | input | 1 | Overload flag belonging to the reading |
| rd_strobe | input | 1 | New-reading strobe |
| hold_mode | input | 1 | 1 = HOLD, 0 = AUTO |
| down_btn | input | 1 | Momentary DOWN control |
| rst_rng_btn | input | 1 | Panel reset-to-least-sensitive |
| rst_rng_remote | input | 1 | Remote reset-to-least-sensitive |
| zero_chk_remote | input | 1 | Remote zero-check, blocks automatic steps |
| rng_hold_remote | input | 1 | Remote range-hold, blocks automatic steps |
| range_code | output | 3 | Current range, 000 least sensitive |
| relay_sel | output | 8 | One-hot range relay select |
| range_exp | output | 4 | BCD exponent digit, 2 to 9 |
| ranging | output | 1 | High while range changes are in progress |
| ovl_blank | output | 1 | Over-range seen in HOLD; display should blank |

## Verification
The assertions assume that every control input is synchronous to `clk`. They also assume that `rd_bcd` and `rd_ovl` stay constant from the strobe until the delayed evaluation, and that DOWN, reset, HOLD changes and evaluations do not fall in the same cycle. The stimulus respects all of this. It changes the reading only while no strobe is pending, drives every input on the falling edge, and waits out each evaluation window before it touches another control.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int RNG_W    = 3;
  localparam int NRNG     = 1 << RNG_W;
  localparam int NDIG     = 4;
  localparam int BCD_W    = 4 * NDIG;
  localparam int EXP_W    = 4;
  localparam int EXP_BASE = 2;

  // digit k of a BCD word, k = 0 is the units digit
  function automatic logic [3:0] dig(input logic [BCD_W-1:0] r, input int k);
    return r[4*k +: 4];
  endfunction

  // value above 1999: top digit beyond 1, or the overload flag
  function automatic logic is_over(input logic [BCD_W-1:0] r, input logic ovl);
    return ovl || (dig(r, NDIG-1) > 4'd1);
  endfunction

  // value below 0100: the two top digits are zero
  function automatic logic is_under(input logic [BCD_W-1:0] r);
    return (dig(r, NDIG-1) == 4'd0) && (dig(r, NDIG-2) == 4'd0);
  endfunction

  function automatic logic [EXP_W-1:0] exp_of(input logic [RNG_W-1:0] c);
    return EXP_W'(c) + EXP_W'(EXP_BASE);
  endfunction
endpackage

// File: rtl/strobe_settle.sv
module strobe_settle #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic eval_o
);
  logic          strobe_q;
  logic [DEPTH-1:0] sr;
  logic          rise;

  assign rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sr       <= '0;
    end else begin
      strobe_q <= strobe;
      sr[0]    <= rise;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign eval_o = sr[DEPTH-1];
endmodule

// File: rtl/range_next.sv
module range_next
  import rng_pkg::*;
(
  input  logic             hold_mode,
  input  logic             leave_hold,
  input  logic             force_top,
  input  logic             press,
  input  logic             eval,
  input  logic             auto_ok,
  input  logic             over,
  input  logic             under,
  input  logic [RNG_W-1:0] code,
  input  logic             rng_flag,
  input  logic             blank,
  output logic [RNG_W-1:0] code_n,
  output logic             rng_flag_n,
  output logic             blank_n
);
  localparam logic [RNG_W-1:0] CODE_MAX = RNG_W'(NRNG - 1);

  always_comb begin
    code_n     = code;
    rng_flag_n = rng_flag;
    blank_n    = blank;
    if (hold_mode) begin
      rng_flag_n = 1'b0;
      if (eval) blank_n = over;
    end else begin
      blank_n = 1'b0;
      if (leave_hold) begin
        code_n     = '0;
        rng_flag_n = 1'b1;
      end else if (force_top) begin
        code_n = '0;
      end else if (press) begin
        code_n = code + RNG_W'(1);
      end else if (eval && auto_ok) begin
        if (over) begin
          code_n     = '0;
          rng_flag_n = 1'b1;
        end else if (under && code != CODE_MAX) begin
          code_n     = code + RNG_W'(1);
          rng_flag_n = 1'b1;
        end else begin
          rng_flag_n = 1'b0;
        end
      end
      if (!auto_ok) rng_flag_n = 1'b0;
    end
  end
endmodule

// File: rtl/range_decode.sv
module range_decode
  import rng_pkg::*;
(
  input  logic [RNG_W-1:0] code,
  output logic [NRNG-1:0]  sel,
  output logic [EXP_W-1:0] exp_d
);
  for (genvar i = 0; i < NRNG; i++) begin : g_sel
    assign sel[i] = (code == RNG_W'(i));
  end
  assign exp_d = exp_of(code);
endmodule

// File: rtl/decade_range_ctrl.sv
module decade_range_ctrl
  import rng_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      rd_bcd,
  input  logic             rd_ovl,
  input  logic             rd_strobe,
  input  logic             hold_mode,
  input  logic             down_btn,
  input  logic             rst_rng_btn,
  input  logic             rst_rng_remote,
  input  logic             zero_chk_remote,
  input  logic             rng_hold_remote,
  output logic [2:0]       range_code,
  output logic [7:0]       relay_sel,
  output logic [3:0]       range_exp,
  output logic             ranging,
  output logic             ovl_blank
);
  // named internal events
  logic             evt_eval, evt_press, evt_leave, evt_force;
  logic             auto_ok, rd_over, rd_under;
  logic             down_q, hold_q;
  logic [RNG_W-1:0] code_q, code_n;
  logic             rng_q, rng_n, blank_q, blank_n;

  strobe_settle #(.DEPTH(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .strobe(rd_strobe), .eval_o(evt_eval)
  );

  assign evt_press = down_btn & ~down_q;
  assign evt_leave = hold_q & ~hold_mode;
  assign evt_force = rst_rng_btn | rst_rng_remote;
  assign auto_ok   = ~zero_chk_remote & ~rng_hold_remote;
  assign rd_over   = is_over(rd_bcd, rd_ovl);
  assign rd_under  = is_under(rd_bcd);

  range_next u_next (
    .hold_mode(hold_mode), .leave_hold(evt_leave), .force_top(evt_force),
    .press(evt_press), .eval(evt_eval), .auto_ok(auto_ok),
    .over(rd_over), .under(rd_under), .code(code_q), .rng_flag(rng_q),
    .blank(blank_q), .code_n(code_n), .rng_flag_n(rng_n), .blank_n(blank_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      rng_q   <= 1'b0;
      blank_q <= 1'b0;
      down_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      code_q  <= code_n;
      rng_q   <= rng_n;
      blank_q <= blank_n;
      down_q  <= down_btn;
      hold_q  <= hold_mode;
    end
  end

  range_decode u_dec (.code(code_q), .sel(relay_sel), .exp_d(range_exp));

  assign range_code = code_q;
  assign ranging    = rng_q;
  assign ovl_blank  = blank_q;
endmodule

// File: rtl/decade_range_ctrl_chk.sv
module decade_range_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_mode,
  input logic       rst_rng_btn,
  input logic       rst_rng_remote,
  input logic       zero_chk_remote,
  input logic       rng_hold_remote,
  input logic [2:0] range_code,
  input logic [7:0] relay_sel,
  input logic [3:0] range_exp,
  input logic       ranging,
  input logic       ovl_blank,
  input logic       evt_eval,
  input logic       evt_press,
  input logic       evt_force,
  input logic       evt_leave
);
  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(relay_sel) == 1 && relay_sel[range_code]);

  p_exp_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    range_exp >= 4'd2 && range_exp <= 4'd9);

  p_step_or_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_code) |-> (range_code == $past(range_code) + 3'd1 || range_code == 3'd0));

  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_code) |-> $past(evt_eval || evt_press || evt_force || evt_leave));

  p_force_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hold_mode && (rst_rng_btn || rst_rng_remote)) |-> range_code == 3'd0);

  p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_mode) |-> $stable(range_code));

  p_blank_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_blank |-> $past(hold_mode));

  p_leave_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_mode, 2) && $past(!hold_mode)) |-> range_code == 3'd0);

  p_flag_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_mode || zero_chk_remote || rng_hold_remote) |-> !ranging);
endmodule

bind decade_range_ctrl decade_range_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
  .rst_rng_btn(rst_rng_btn), .rst_rng_remote(rst_rng_remote),
  .zero_chk_remote(zero_chk_remote), .rng_hold_remote(rng_hold_remote),
  .range_code(range_code), .relay_sel(relay_sel), .range_exp(range_exp),
  .ranging(ranging), .ovl_blank(ovl_blank), .evt_eval(evt_eval),
  .evt_press(evt_press), .evt_force(evt_force), .evt_leave(evt_leave)
);

// File: tb/tb_decade_range_ctrl.sv
`timescale 1ns/1ps
module tb_decade_range_ctrl;
  localparam int SETTLE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rd_bcd = 16'h0500;
  logic        rd_ovl = 1'b0, rd_strobe = 1'b0, hold_mode = 1'b0, down_btn = 1'b0;
  logic        rst_rng_btn = 1'b0, rst_rng_remote = 1'b0;
  logic        zero_chk_remote = 1'b0, rng_hold_remote = 1'b0;
  logic [2:0]  range_code;
  logic [7:0]  relay_sel;
  logic [3:0]  range_exp;
  logic        ranging, ovl_blank;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  decade_range_ctrl #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .rd_bcd(rd_bcd), .rd_ovl(rd_ovl),
    .rd_strobe(rd_strobe), .hold_mode(hold_mode), .down_btn(down_btn),
    .rst_rng_btn(rst_rng_btn), .rst_rng_remote(rst_rng_remote),
    .zero_chk_remote(zero_chk_remote), .rng_hold_remote(rng_hold_remote),
    .range_code(range_code), .relay_sel(relay_sel), .range_exp(range_exp),
    .ranging(ranging), .ovl_blank(ovl_blank)
  );

  // {reading[20:5], ovl[4], expected code[3:1], expected ranging[0]}
  localparam logic [20:0] VEC [0:15] = '{
    {16'h0050, 1'b0, 3'd1, 1'b1},  // R3
    {16'h0050, 1'b0, 3'd2, 1'b1},  // R3
    {16'h0500, 1'b0, 3'd2, 1'b0},  // R4 window, R11
    {16'h2500, 1'b0, 3'd0, 1'b1},  // R4 over
    {16'h0099, 1'b0, 3'd1, 1'b1},  // R3 edge
    {16'h0100, 1'b0, 3'd1, 1'b0},  // R4 lower edge
    {16'h1999, 1'b0, 3'd1, 1'b0},  // R4 upper edge
    {16'h1999, 1'b1, 3'd0, 1'b1},  // R4 overload flag
    {16'h0000, 1'b0, 3'd1, 1'b1},
    {16'h0000, 1'b0, 3'd2, 1'b1},
    {16'h0000, 1'b0, 3'd3, 1'b1},
    {16'h0000, 1'b0, 3'd4, 1'b1},
    {16'h0000, 1'b0, 3'd5, 1'b1},
    {16'h0000, 1'b0, 3'd6, 1'b1},
    {16'h0000, 1'b0, 3'd7, 1'b1},
    {16'h0000, 1'b0, 3'd7, 1'b0}   // R3 stays at most sensitive
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_code(input string tag, input int exp);
    chk(range_code == 3'(exp), tag, range_code, exp);
  endtask

  task automatic chk_outs(input string tag);
    int c = range_code;
    chk(relay_sel == 8'(1 << c), {tag, " R2 sel"}, relay_sel, 1 << c);
    chk(range_exp == 4'(c + 2), {tag, " R2 exp"}, range_exp, c + 2);
  endtask

  // one-cycle strobe, then wait until the evaluation edge has passed
  task automatic do_eval(input logic [15:0] r, input logic ov);
    rd_bcd = r; rd_ovl = ov;
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic press();
    @(negedge clk); down_btn = 1'b1;
    @(negedge clk); down_btn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_code("R1 reset code", 0);
    chk(ranging == 1'b0, "R1 reset ranging", ranging, 0);
    chk(ovl_blank == 1'b0, "R1 reset blank", ovl_blank, 0);
    chk_outs("R1");

    for (int i = 0; i < 16; i++) begin
      do_eval(VEC[i][20:5], VEC[i][4]);
      chk_code($sformatf("R3/R4 vec%0d code", i), int'(VEC[i][3:1]));
      chk(ranging == VEC[i][0], $sformatf("R11 vec%0d ranging", i), ranging, int'(VEC[i][0]));
      chk_outs($sformatf("vec%0d", i));
    end

    // R6 wrap and single step on held button
    press();
    chk_code("R6 wrap", 0);
    press();
    chk_code("R6 step", 1);
    @(negedge clk); down_btn = 1'b1;
    repeat (5) @(negedge clk);
    down_btn = 1'b0; @(negedge clk);
    chk_code("R6 held once", 2);

    // R5 settle delay and once per long strobe
    rd_bcd = 16'h0050; rd_ovl = 1'b0;
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk);
    repeat (SETTLE - 1) @(negedge clk);
    chk_code("R5 before settle", 2);
    @(negedge clk);
    chk_code("R5 at settle", 3);
    rd_strobe = 1'b0;
    repeat (10) @(negedge clk);
    chk_code("R5 once per strobe", 3);

    // R8 remote inhibits
    zero_chk_remote = 1'b1;
    do_eval(16'h0050, 1'b0);
    chk_code("R8 zero-check", 3);
    chk(ranging == 1'b0, "R11 low under zero-check", ranging, 0);
    press();
    chk_code("R8 down still acts", 4);
    zero_chk_remote = 1'b0;
    rng_hold_remote = 1'b1;
    do_eval(16'h2500, 1'b0);
    chk_code("R8 range-hold", 4);
    rng_hold_remote = 1'b0;

    // R7 forced top range
    @(negedge clk); rst_rng_btn = 1'b1;
    @(negedge clk);
    chk_code("R7 panel force", 0);
    do_eval(16'h0050, 1'b0);
    chk_code("R7 held at top", 0);
    rst_rng_btn = 1'b0;
    press();
    rst_rng_remote = 1'b1;
    @(negedge clk);
    chk_code("R7 remote force", 0);
    rst_rng_remote = 1'b0;
    do_eval(16'h0050, 1'b0);
    chk_code("R7 resumes", 1);
    do_eval(16'h0050, 1'b0);

    // R9 HOLD behaviour
    hold_mode = 1'b1;
    @(negedge clk);
    do_eval(16'h0050, 1'b0);
    chk_code("R9 hold ignores under", 2);
    chk(ranging == 1'b0, "R11 low in hold", ranging, 0);
    press();
    chk_code("R9 hold ignores down", 2);
    @(negedge clk); rst_rng_btn = 1'b1;
    @(negedge clk); rst_rng_btn = 1'b0;
    chk_code("R9 hold ignores reset", 2);
    do_eval(16'h2500, 1'b0);
    chk(ovl_blank == 1'b1, "R9 blank on over", ovl_blank, 1);
    chk_code("R9 over keeps code", 2);
    do_eval(16'h0500, 1'b0);
    chk(ovl_blank == 1'b0, "R9 blank clears", ovl_blank, 0);
    do_eval(16'h2500, 1'b0);

    // R10 leaving HOLD
    @(negedge clk); hold_mode = 1'b0;
    @(negedge clk);
    chk_code("R10 leave hold", 0);
    chk(ranging == 1'b1, "R10 ranging raised", ranging, 1);
    chk(ovl_blank == 1'b0, "R10 blank cleared", ovl_blank, 0);
    do_eval(16'h0050, 1'b0);
    chk_code("R10 walks down", 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule